// File: doc/BRIEF.md
# Inverting Latching Bus Transceiver

This block moves a 9-bit word between a local tri-state port (side A) and a shared backplane port (side B) on which every attached device can only pull a line low or let it float high. Data is inverted in both directions: a one on side A becomes a low bus line, and a low bus line becomes a one on side A. A chip-disable input takes the block off both ports. A direction input chooses between sending (A to B) and receiving (B to A).

The sending path has a register that is loaded on rising edges of a separate capture strobe. A bypass input turns this register into a plain pass-through. The receiving path has a latch. It follows the bus while its enable is high and freezes when the enable drops. The bus side is split into a per-bit pull-low enable and a resolved bus input, and the local side into data out, per-bit output enable and data in. This keeps the model free of bidirectional nets. The block runs on a system clock. The capture strobe is sampled on that clock, and the latch stores its value on clock edges while its enable is high.

Top module: `btl_latch_xcvr`

## Requirements
- R1: While `chip_dis` is 1, `a_oe` and `b_drive_low` are all zero, for every value of the other inputs.
- R2: With `chip_dis`=0 and `xmit`=1, `a_oe` is all zero. Bit i of `b_drive_low` is 1 exactly when the sent data bit i is 1, so the resolved bus carries the inverse of the data.
- R3: When sending with `reg_bypass`=1, the sent data is `a_in` itself, in the same cycle and with no clock delay.
- R4: When sending with `reg_bypass`=0, the sent data is the register contents. A rising edge of `aclk`, seen at a clock edge, loads `a_in` from that clock edge, and `b_drive_low` shows the new word from the following cycle. With no new `aclk` edge the word is held, whatever `a_in` does.
- R5: With `chip_dis`=0 and `xmit`=0, `b_drive_low` is all zero and `a_oe` is all ones, so the two ports never drive at the same time.
- R6: While receiving with `latch_en`=1, `a_out` equals the bitwise inverse of `b_in` in the same cycle.
- R7: While `latch_en`=0, `a_out` holds the inverse of `b_in` as sampled at the last clock edge with `latch_en`=1, and later changes of `b_in` have no effect.
- R8: After reset, the send register holds zero (bus released in registered mode) and the receive latch holds zero.
- R9: Holding `aclk` high loads the register once only. Changes of `a_in` while `aclk` stays high, or after it falls, are not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_dis | input | 1 | 1 releases both ports |
| xmit | input | 1 | 1 sends A to B, 0 receives B to A |
| reg_bypass | input | 1 | 1 makes the send register pass-through |
| aclk | input | 1 | Capture strobe of the send register, rising edge active |
| latch_en | input | 1 | 1 makes the receive latch follow the bus |
| a_in | input | 9 | Local data in (send side) |
| a_out | output | 9 | Local data out (receive side) |
| a_oe | output | 9 | Per-bit output enable of `a_out` |
| b_in | input | 9 | Resolved backplane level |
| b_drive_low | output | 9 | Per-bit pull-low enable onto the backplane |

## Verification
The hardest states to reach are the held ones. One is a send register that must ignore `a_in` while `aclk` stays high. The other is a receive latch that must ignore a bus changed by another device. The bench loads a word, then keeps the strobe high or the enable low while it drives the complement pattern, and checks that the old word survives on the ports. It also runs an external pull-low source next to the block, so received values come from a genuinely wired-OR bus.

// File: rtl/btl_xcvr_pkg.sv
package btl_xcvr_pkg;
  typedef enum logic [1:0] {
    XCVR_OFF  = 2'd0,
    XCVR_SEND = 2'd1,
    XCVR_RECV = 2'd2
  } xcvr_mode_e;

  function automatic xcvr_mode_e decode_mode(input logic dis, input logic send);
    if (dis)       return XCVR_OFF;
    else if (send) return XCVR_SEND;
    else           return XCVR_RECV;
  endfunction
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[LAST];
endmodule

// File: rtl/xcvr_tx_reg.sv
module xcvr_tx_reg #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aclk,
  input  logic             bypass,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic             strobe_q, strobe_d;
  logic [WIDTH-1:0] word_q, word_d;
  logic             load_en;

  always_comb begin
    strobe_d = aclk;
    load_en  = aclk & ~strobe_q;
    word_d   = word_q;
    if (load_en) word_d = d_in;
  end

  // strobe history resets high so a strobe already high at reset release does not load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe_d;
      word_q   <= word_d;
    end
  end

  assign d_out = bypass ? d_in : word_q;

  // R4 R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(aclk) |=> $stable(word_q));
endmodule

// File: rtl/xcvr_rx_latch.sv
module xcvr_rx_latch #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [WIDTH-1:0] bus_lvl,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] held_q, held_d;
  logic [WIDTH-1:0] inv_lvl;

  always_comb begin
    inv_lvl = ~bus_lvl;
    held_d  = held_q;
    if (open_en) held_d = inv_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q_out = open_en ? inv_lvl : held_q;

  // R7
  latch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_en |=> $stable(held_q));
endmodule

// File: rtl/xcvr_port_ctl.sv
module xcvr_port_ctl
  import btl_xcvr_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             chip_dis,
  input  logic             xmit,
  input  logic [WIDTH-1:0] send_word,
  output logic [WIDTH-1:0] pull_low,
  output logic [WIDTH-1:0] local_oe
);
  xcvr_mode_e mode;
  logic       send_on, recv_on;

  always_comb begin
    mode    = decode_mode(chip_dis, xmit);
    send_on = (mode == XCVR_SEND);
    recv_on = (mode == XCVR_RECV);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pull_low[i] = send_on & send_word[i];
    assign local_oe[i] = recv_on;
  end

  // R5
  no_contention_chk: assert final (!((|pull_low) && (|local_oe)));
endmodule

// File: rtl/btl_latch_xcvr.sv
module btl_latch_xcvr #(
  parameter int WIDTH       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_dis,
  input  logic             xmit,
  input  logic             reg_bypass,
  input  logic             aclk,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_drive_low
);
  logic             rst_n_int;
  logic [WIDTH-1:0] send_word;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  xcvr_tx_reg #(.WIDTH(WIDTH)) tx_i (
    .clk(clk), .rst_n(rst_n_int), .aclk(aclk), .bypass(reg_bypass),
    .d_in(a_in), .d_out(send_word));

  xcvr_rx_latch #(.WIDTH(WIDTH)) rx_i (
    .clk(clk), .rst_n(rst_n_int), .open_en(latch_en),
    .bus_lvl(b_in), .q_out(a_out));

  xcvr_port_ctl #(.WIDTH(WIDTH)) ctl_i (
    .chip_dis(chip_dis), .xmit(xmit), .send_word(send_word),
    .pull_low(b_drive_low), .local_oe(a_oe));

  // R1
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    chip_dis |-> (b_drive_low == '0 && a_oe == '0));

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!chip_dis && xmit && reg_bypass) |-> (b_drive_low == a_in));

  // R6
  recv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!chip_dis && !xmit && latch_en) |-> (a_out == ~b_in));

  // R5
  recv_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!chip_dis && !xmit) |-> (b_drive_low == '0 && a_oe == '1));
endmodule

// File: tb/btl_latch_xcvr_tb_top.sv
module btl_latch_xcvr_tb_top;
  localparam int W = 9;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         chip_dis, xmit, reg_bypass, aclk, latch_en;
  logic [W-1:0] a_in, a_out, a_oe, b_in, b_drive_low, ext_pull;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  // wired-OR bus: any pull-low source makes the line low
  assign b_in = ~(b_drive_low | ext_pull);

  btl_latch_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .chip_dis(chip_dis), .xmit(xmit),
    .reg_bypass(reg_bypass), .aclk(aclk), .latch_en(latch_en),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in),
    .b_drive_low(b_drive_low));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chip_dis = 1'b0; xmit = 1'b1; reg_bypass = 1'b0;
    aclk = 1'b0; latch_en = 1'b0; a_in = '0; ext_pull = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R8: registered send path released after reset
    a_in = ONES; #1;
    check("R8 send reg", b_drive_low, '0);
    xmit = 1'b0; #1;
    check("R8 recv latch", a_out, '0);
    check("R5 oe after reset", a_oe, ONES);
    cyc(1);

    // R1: disable overrides every combination
    chip_dis = 1'b1;
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 512; v += 37) begin
        xmit = m[0]; reg_bypass = m[1]; latch_en = m[2]; a_in = W'(v);
        #1;
        check("R1 bus released", b_drive_low, '0);
        check("R1 local hi-z", a_oe, '0);
        cyc(1);
      end
    end
    chip_dis = 1'b0; latch_en = 1'b0;

    // R2 R3: bypass send, full sweep
    xmit = 1'b1; reg_bypass = 1'b1;
    for (int v = 0; v < 512; v++) begin
      a_in = W'(v); #1;
      check("R3 bypass pull", b_drive_low, W'(v));
      check("R2 bus inverted", b_in, ~W'(v));
      check("R2 local hi-z", a_oe, '0);
      cyc(1);
    end

    // R4 R9: registered send
    reg_bypass = 1'b0;
    for (int v = 1; v < 512; v += 51) begin
      a_in = W'(v); aclk = 1'b1;
      cyc(1);
      check("R4 load", b_drive_low, W'(v));
      a_in = ~W'(v);
      cyc(3);
      check("R9 level no reload", b_drive_low, W'(v));
      aclk = 1'b0;
      cyc(2);
      check("R4 hold", b_drive_low, W'(v));
    end

    // R5 R6: receive, latch open, external pull-low sweep
    xmit = 1'b0; latch_en = 1'b1; a_in = ONES;
    for (int v = 0; v < 512; v++) begin
      ext_pull = W'(v); #1;
      check("R6 follow", a_out, W'(v));
      check("R5 no pull", b_drive_low, '0);
      check("R5 local oe", a_oe, ONES);
      cyc(1);
    end

    // R7: latch closed ignores bus
    for (int v = 3; v < 512; v += 67) begin
      latch_en = 1'b1; ext_pull = W'(v);
      cyc(1);
      latch_en = 1'b0;
      cyc(1);
      ext_pull = ~W'(v);
      cyc(2);
      check("R7 frozen", a_out, W'(v));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule